// File: doc/BRIEF.md
# Single-Wire LED Pixel Encoder

This block turns a stream of pixel bytes into a pulse-width-coded waveform on one output wire, as used by chains of addressable LEDs. Each bit occupies a fixed-length slot that opens with the line high. A short high time encodes a zero and a long high time encodes a one. The line then stays low for the rest of the slot. Software-side logic requests a frame by pulsing a start input together with a byte count. The bytes themselves arrive over a valid/ready handshake.

A mode input picks a fast or a slow bit rate. Every pulse length is converted from nanoseconds to clock cycles at elaboration, using a clock-frequency parameter. When the last slot of a frame ends, the line is held low for a latch interval, and then a one-cycle done pulse is raised. If the next byte has not arrived by the time the current byte finishes, the frame is cut short. An underrun pulse is raised and the line never stretches a slot.

Top module: `pxenc_top`

## Requirements
- R1: After reset and whenever no frame is in progress, `led_out`, `busy` and `done` are low.
- R2: Each byte is sent most significant bit first. In fast mode (`slow_mode`=0 at start), with the default 50 MHz clock, a zero bit stays high for 17 cycles and a one bit for 40 cycles.
- R3: In slow mode (`slow_mode`=1 at start), with the default clock, a zero bit stays high for 25 cycles and a one bit for 60 cycles.
- R4: Successive rising edges within a frame are exactly one bit period apart: 62 cycles in fast mode and 125 in slow mode. This holds across byte boundaries too.
- R5: `done` pulses for exactly one cycle, one full bit period plus the latch time (2500 cycles, i.e. 50 us) after the last rising edge. `busy` stays high until then.
- R6: `slow_mode` is sampled only when a frame is accepted. Changing it during the frame does not alter that frame's timing.
- R7: A start with `frame_bytes`=0 raises `done` in the next cycle, produces no pulse, and leaves `busy` low.
- R8: If a byte is still owed when the current byte's last slot ends and none is waiting, `underrun` pulses for one cycle with the line low. The frame then enters its latch interval and ends with `done`, and no further pulses are sent.
- R9: `px_ready` is high only while the frame still owes bytes and the one-byte holding slot is empty. Once all bytes of a frame have been accepted, it stays low for the rest of that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Request a frame; accepted only while idle |
| frame_bytes | input | CNT_W | Number of bytes in the requested frame |
| slow_mode | input | 1 | 1 selects the slow bit rate, 0 the fast one |
| px_data | input | 8 | Pixel byte |
| px_valid | input | 1 | `px_data` holds a byte |
| px_ready | output | 1 | Encoder takes the byte at this edge |
| led_out | output | 1 | Serial data line |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse at the end of a frame |
| underrun | output | 1 | One-cycle pulse when a byte arrived too late |

## Verification
The hardest case to reach is the underrun. It needs the input side to fall behind only after the encoder has already started clocking bits out. The bench reaches it by requesting a three-byte frame and supplying just one byte. The encoder then runs dry at its first byte boundary. A second hard case is a mode change in the middle of a frame: the bench flips `slow_mode` right after the start is taken and still expects fast-mode timing for every bit.

// File: rtl/pxenc_pkg.sv
package pxenc_pkg;

  typedef enum logic [1:0] {
    S_IDLE,
    S_FETCH,
    S_SEND,
    S_LATCH
  } pxenc_state_t;

  // clock cycles covering a duration: hz * ns / 1e9, truncated
  function automatic int unsigned ns_to_cyc(longint unsigned hz, longint unsigned ns);
    longint unsigned prod;
    prod = (hz * ns) / 64'd1_000_000_000;
    return int'(prod);
  endfunction

endpackage

// File: rtl/pxenc_timing.sv
module pxenc_timing import pxenc_pkg::*; #(
  parameter longint unsigned CLK_HZ      = 50_000_000,
  parameter int unsigned     FAST_ZERO_NS = 350,
  parameter int unsigned     FAST_ONE_NS  = 800,
  parameter int unsigned     FAST_PER_NS  = 1250,
  parameter int unsigned     SLOW_ZERO_NS = 500,
  parameter int unsigned     SLOW_ONE_NS  = 1200,
  parameter int unsigned     SLOW_PER_NS  = 2500,
  parameter int unsigned     PH_W         = 8
) (
  input  logic            mode_slow,
  output logic [PH_W-1:0] hi_zero,
  output logic [PH_W-1:0] hi_one,
  output logic [PH_W-1:0] period
);
  localparam int unsigned F_ZERO = ns_to_cyc(CLK_HZ, FAST_ZERO_NS);
  localparam int unsigned F_ONE  = ns_to_cyc(CLK_HZ, FAST_ONE_NS);
  localparam int unsigned F_PER  = ns_to_cyc(CLK_HZ, FAST_PER_NS);
  localparam int unsigned S_ZERO = ns_to_cyc(CLK_HZ, SLOW_ZERO_NS);
  localparam int unsigned S_ONE  = ns_to_cyc(CLK_HZ, SLOW_ONE_NS);
  localparam int unsigned S_PER  = ns_to_cyc(CLK_HZ, SLOW_PER_NS);

  assign hi_zero = mode_slow ? PH_W'(S_ZERO) : PH_W'(F_ZERO);
  assign hi_one  = mode_slow ? PH_W'(S_ONE)  : PH_W'(F_ONE);
  assign period  = mode_slow ? PH_W'(S_PER)  : PH_W'(F_PER);

  initial begin
    assert (F_ONE < F_PER && S_ONE < S_PER && F_ZERO > 0 && S_ZERO > 0)
      else $error("pulse widths must fit inside the bit period");
  end
endmodule

// File: rtl/pxenc_bit_timer.sv
module pxenc_bit_timer #(
  parameter int unsigned PH_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            bit_val,
  input  logic [PH_W-1:0] hi_zero,
  input  logic [PH_W-1:0] hi_one,
  input  logic [PH_W-1:0] period,
  output logic            line,
  output logic            slot_end
);
  logic [PH_W-1:0] ph;
  logic [PH_W-1:0] hi_len;

  assign hi_len   = bit_val ? hi_one : hi_zero;
  assign slot_end = run && (ph == period - 1'b1);
  assign line     = run && (ph < hi_len);

  always_ff @(posedge clk) begin
    if (!rst_n)                ph <= '0;
    else if (!run || slot_end) ph <= '0;
    else                       ph <= ph + 1'b1;
  end

  // a slot always closes with the line low
  assert_slot_closes_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end |-> !line);
  // a rising edge only opens a fresh slot
  assert_rise_opens_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line) |-> (ph == '0));
endmodule

// File: rtl/pxenc_feed.sv
module pxenc_feed #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] count,
  input  logic             active,
  input  logic             take,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  output logic [7:0]       nxt,
  output logic             nxt_v
);
  logic [CNT_W-1:0] owed;
  logic             accept;

  assign in_ready = active && !nxt_v && (owed != '0);
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owed  <= '0;
      nxt   <= '0;
      nxt_v <= 1'b0;
    end else if (load) begin
      owed  <= count;
      nxt_v <= 1'b0;
    end else if (accept) begin
      nxt   <= in_data;
      nxt_v <= 1'b1;
      owed  <= owed - 1'b1;
    end else if (take) begin
      nxt_v <= 1'b0;
    end
  end

  assert_accept_fills_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> nxt_v);
  assert_ready_needs_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (nxt_v && !take) |=> !in_ready);
endmodule

// File: rtl/pxenc_top.sv
module pxenc_top import pxenc_pkg::*; #(
  parameter longint unsigned CLK_HZ       = 50_000_000,
  parameter int unsigned     CNT_W        = 16,
  parameter int unsigned     FAST_ZERO_NS = 350,
  parameter int unsigned     FAST_ONE_NS  = 800,
  parameter int unsigned     FAST_PER_NS  = 1250,
  parameter int unsigned     SLOW_ZERO_NS = 500,
  parameter int unsigned     SLOW_ONE_NS  = 1200,
  parameter int unsigned     SLOW_PER_NS  = 2500,
  parameter int unsigned     LATCH_NS     = 50_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic [CNT_W-1:0] frame_bytes,
  input  logic             slow_mode,
  input  logic [7:0]       px_data,
  input  logic             px_valid,
  output logic             px_ready,
  output logic             led_out,
  output logic             busy,
  output logic             done,
  output logic             underrun
);
  localparam int unsigned MAX_PER = ns_to_cyc(CLK_HZ,
    (SLOW_PER_NS > FAST_PER_NS) ? SLOW_PER_NS : FAST_PER_NS);
  localparam int unsigned PH_W    = $clog2(MAX_PER + 1);
  localparam int unsigned LAT_CYC = ns_to_cyc(CLK_HZ, LATCH_NS);
  localparam int unsigned LAT_W   = $clog2(LAT_CYC + 1);
  localparam logic [LAT_W-1:0] LAT_LAST = LAT_W'(LAT_CYC - 1);

  pxenc_state_t     state;
  logic             mode_q;
  logic [7:0]       shreg;
  logic [2:0]       bit_idx;
  logic [CNT_W-1:0] to_send;
  logic [LAT_W-1:0] lcnt;

  logic [PH_W-1:0]  hi_zero, hi_one, period;
  logic             slot_end;
  logic             nxt_v;
  logic [7:0]       nxt;

  // named internal events
  logic frame_accept, zero_frame, take_byte, byte_end, starve, latch_end;

  assign frame_accept = (state == S_IDLE) && frame_start && (frame_bytes != '0);
  assign zero_frame   = (state == S_IDLE) && frame_start && (frame_bytes == '0);
  assign byte_end     = (state == S_SEND) && slot_end && (bit_idx == 3'd0);
  assign starve       = byte_end && (to_send != '0) && !nxt_v;
  assign take_byte    = ((state == S_FETCH) && nxt_v) ||
                        (byte_end && (to_send != '0) && nxt_v);
  assign latch_end    = (state == S_LATCH) && (lcnt == LAT_LAST);
  assign busy         = (state != S_IDLE);

  pxenc_timing #(
    .CLK_HZ(CLK_HZ), .FAST_ZERO_NS(FAST_ZERO_NS), .FAST_ONE_NS(FAST_ONE_NS),
    .FAST_PER_NS(FAST_PER_NS), .SLOW_ZERO_NS(SLOW_ZERO_NS), .SLOW_ONE_NS(SLOW_ONE_NS),
    .SLOW_PER_NS(SLOW_PER_NS), .PH_W(PH_W)
  ) u_timing (
    .mode_slow(mode_q), .hi_zero(hi_zero), .hi_one(hi_one), .period(period)
  );

  pxenc_bit_timer #(.PH_W(PH_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(state == S_SEND), .bit_val(shreg[7]),
    .hi_zero(hi_zero), .hi_one(hi_one), .period(period),
    .line(led_out), .slot_end(slot_end)
  );

  pxenc_feed #(.CNT_W(CNT_W)) u_feed (
    .clk(clk), .rst_n(rst_n), .load(frame_accept), .count(frame_bytes),
    .active((state == S_FETCH) || (state == S_SEND)), .take(take_byte),
    .in_valid(px_valid), .in_data(px_data), .in_ready(px_ready),
    .nxt(nxt), .nxt_v(nxt_v)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      mode_q   <= 1'b0;
      shreg    <= '0;
      bit_idx  <= '0;
      to_send  <= '0;
      lcnt     <= '0;
      done     <= 1'b0;
      underrun <= 1'b0;
    end else begin
      done     <= 1'b0;
      underrun <= 1'b0;
      case (state)
        S_IDLE: begin
          if (zero_frame) done <= 1'b1;
          if (frame_accept) begin
            mode_q  <= slow_mode;
            to_send <= frame_bytes;
            state   <= S_FETCH;
          end
        end
        S_FETCH: begin
          if (take_byte) begin
            shreg   <= nxt;
            bit_idx <= 3'd7;
            to_send <= to_send - 1'b1;
            state   <= S_SEND;
          end
        end
        S_SEND: begin
          if (slot_end) begin
            if (bit_idx != 3'd0) begin
              shreg   <= {shreg[6:0], 1'b0};
              bit_idx <= bit_idx - 1'b1;
            end else if (take_byte) begin
              shreg   <= nxt;
              bit_idx <= 3'd7;
              to_send <= to_send - 1'b1;
            end else begin
              underrun <= starve;
              lcnt     <= '0;
              state    <= S_LATCH;
            end
          end
        end
        S_LATCH: begin
          lcnt <= lcnt + 1'b1;
          if (latch_end) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !led_out);
  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_after_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(zero_frame)) |-> (!led_out && !$past(led_out)));
  assert_mode_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mode_q));
  assert_empty_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    zero_frame |=> (done && !busy));
  assert_underrun_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> (!led_out && state == S_LATCH));
endmodule

// File: tb/tb_pxenc_top.sv
module tb_pxenc_top;
  localparam int CLK_MHZ = 50;
  localparam int LAT = 50 * CLK_MHZ;

  typedef struct { int hi; int per; string req; } slot_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0;
  logic [15:0] frame_bytes = '0;
  logic        slow_mode = 1'b0;
  logic [7:0]  px_data = '0;
  logic        px_valid = 1'b0;
  logic        px_ready, led_out, busy, done, underrun;

  int checks = 0, fails = 0, n = 0, rises = 0, unders = 0;
  slot_t q[$];
  slot_t cur;
  int last_rise = 0, rise_at = 0;
  bit have_prev = 1'b0;
  logic prev_led = 1'b0;
  logic [7:0] mem [4];

  always #10 clk = ~clk;

  pxenc_top dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_bytes(frame_bytes),
    .slow_mode(slow_mode), .px_data(px_data), .px_valid(px_valid), .px_ready(px_ready),
    .led_out(led_out), .busy(busy), .done(done), .underrun(underrun)
  );

  function automatic int cyc(int ns);
    return (ns * CLK_MHZ) / 1000;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // monitor: pops expected slots as the line produces them
  always @(negedge clk) begin
    n++;
    if (rst_n) begin
      if (led_out && !prev_led) begin
        rises++;
        if (have_prev) chk(n - last_rise == cur.per, "R4", n - last_rise, cur.per);
        if (q.size() == 0) chk(1'b0, "R8 unexpected pulse", 1, 0);
        else cur = q.pop_front();
        last_rise = n;
        have_prev = 1'b1;
      end
      if (!led_out && prev_led)
        chk(n - last_rise == cur.hi, cur.req, n - last_rise, cur.hi);
      if (underrun) begin
        unders++;
        chk(!led_out, "R8 line low", led_out, 0);
      end
      if (done) begin
        if (have_prev) chk(n - last_rise == cur.per + LAT, "R5", n - last_rise, cur.per + LAT);
        chk(q.size() == 0, "R5 all bits sent", q.size(), 0);
        have_prev = 1'b0;
      end
    end
    prev_led = led_out;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    summary();
  end

  task automatic push_byte(logic [7:0] d, bit slow);
    for (int b = 7; b >= 0; b--) begin
      slot_t s;
      s.per = slow ? cyc(2500) : cyc(1250);
      if (slow) s.hi = d[b] ? cyc(1200) : cyc(500);
      else      s.hi = d[b] ? cyc(800)  : cyc(350);
      s.req = slow ? "R3" : "R2";
      q.push_back(s);
    end
  endtask

  task automatic run_frame(int cnt, bit slow, int supply, bit flip);
    bit ready_late = 1'b0;
    @(negedge clk);
    frame_bytes = 16'(cnt); slow_mode = slow; frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    if (flip) slow_mode = !slow;  // R6: must not affect this frame
    for (int i = 0; i < supply; i++) begin
      px_data = mem[i]; px_valid = 1'b1;
      while (!px_ready) @(negedge clk);
      push_byte(mem[i], slow);
      @(negedge clk);
    end
    px_valid = 1'b0;
    while (!done) begin
      if (px_ready) ready_late = 1'b1;
      @(negedge clk);
    end
    if (supply == cnt) chk(!ready_late, "R9 ready after last byte", ready_late, 0);
    chk(!busy, "R5 busy clears with done", busy, 0);
    @(negedge clk);
    chk(!done, "R5 done one cycle", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!led_out && !busy && !done, "R1 reset", {led_out, busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!led_out && !busy && !px_ready, "R1 idle", {led_out, busy, px_ready}, 0);

    // R2 R4 R5 R9: fast frame, two bytes back to back
    mem[0] = 8'hA5; mem[1] = 8'h3C;
    run_frame(2, 1'b0, 2, 1'b0);
    chk(rises == 16, "R2 pulse count", rises, 16);

    // R3 R4: slow frame, three bytes
    mem[0] = 8'h81; mem[1] = 8'hFF; mem[2] = 8'h00;
    run_frame(3, 1'b1, 3, 1'b0);
    chk(rises == 40, "R3 pulse count", rises, 40);

    // R6: mode flipped to slow right after a fast start
    mem[0] = 8'h5A;
    run_frame(1, 1'b0, 1, 1'b1);
    chk(rises == 48, "R6 pulse count", rises, 48);
    slow_mode = 1'b0;

    // R7: empty frame
    @(negedge clk);
    frame_bytes = '0; frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    chk(done && !busy, "R7 done next cycle", {done, busy}, 2);
    repeat (5) @(negedge clk);
    chk(rises == 48 && !busy, "R7 no pulses", rises, 48);

    // R8: three bytes owed, only one supplied
    mem[0] = 8'hC3;
    run_frame(3, 1'b0, 1, 1'b0);
    chk(unders == 1, "R8 underrun pulse", unders, 1);
    chk(rises == 56, "R8 no bits after starve", rises, 56);
    repeat (20) @(negedge clk);
    chk(!led_out && !busy && !underrun, "R1 idle after frames", {led_out, busy, underrun}, 0);

    summary();
  end
endmodule